// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers a parameterised number of external interrupt inputs (1 to 32) and combines them into a single interrupt request for the processor. Each input first passes through a two-flop synchroniser. A per-line detector then watches for either an active level or an active edge. The detector's sense and polarity are chosen per line by three configuration registers. A detected event sets a sticky pending bit. A pending bit reaches the output only when that line's enable bit is also set.

Software reaches the block through a simple word-addressed register port. Writes take effect on the clock edge, and reads are combinational. The enable mask has three views: a set-only port, a clear-only port and a read-only copy. Pending bits are acknowledged by writing ones to a clear port. The configuration registers keep bits only for lines that exist. Writing all ones and reading the value back therefore tells software how many lines are present. A separate one-bit control arms the non-maskable interrupt path and is brought out as a port.

Top module: `xint_ctrl`

## Requirements
- R1: While and after a synchronous reset, the enable mask, pending status, non-maskable enable and the mode, edge and level registers all read zero, and `irq_out` and `nmi_enable` are low.
- R2: Writing to byte offset 0x00 sets every mask bit where the data bit is 1. Writing to offset 0x04 clears every mask bit where the data bit is 1. Zero data bits leave the mask unchanged. The mask reads back at offset 0x08, and writes there have no effect.
- R3: Pending status reads at offset 0x0C. Writing 1s to offset 0x10 clears those pending bits on the next edge. Zero bits leave their pending bits unchanged.
- R4: `irq_out` is high exactly when some line has both its pending bit and its mask bit set.
- R5: The mode (0x14), edge (0x18) and level (0x1C) registers store only the low NUM_LINES bits. Bits above NUM_LINES, in these registers and in mask and status, read as 0. Writing all ones to mode and reading it back returns 2^NUM_LINES-1.
- R6: With mode bit 0 the line is level sensed: level bit 1 means active-high and level bit 0 means active-low. The pending bit is set on every clock cycle the active level is present, so a clear while the level persists has no lasting effect.
- R7: With mode bit 1 the line is edge sensed: edge bit 1 means rising and edge bit 0 means falling. Only a new edge of the selected direction sets the pending bit, and a steady input after a clear does not set it again.
- R8: A change on `ext_in` can set a pending bit no earlier than the third rising clock edge after the change, because of the two-flop synchroniser.
- R9: Bit 0 of offset 0x24 holds the non-maskable enable. It reads back in bit 0, the other bits read 0, and it drives `nmi_enable`.
- R10: When a clear and a new detection hit the same line in the same cycle, the pending bit stays set.
- R11: A read from an offset that maps to no register (for example 0x20 or 0x3C) returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe for the current cycle |
| bus_addr | input | 6 | Byte offset of the register accessed; the low two bits are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ext_in | input | NUM_LINES | Asynchronous external interrupt inputs |
| irq_out | output | 1 | Combined interrupt request |
| nmi_enable | output | 1 | Non-maskable interrupt enable state |

## Verification
The bench builds the block with NUM_LINES = 5. With only five lines, the upper 27 bits of every per-line register must read as zero, and the all-ones write to the mode register must return 0x1F. This makes the line-count discovery and the masking of unimplemented bits directly observable. Five lines also keep the space of mode, polarity and mask combinations small enough that a few thousand random cycles visit each line in level and edge sensing, in both polarities, and with clears that collide with detections.

// File: rtl/xint_pkg.sv
// Package: register offsets and helpers shared by the interrupt controller.
// Assumes a word-addressed map decoded from byte offset bits [5:2].
package xint_pkg;
    localparam int REG_AW = 6;
    localparam int DATA_W = 32;
    localparam int WORD_W = REG_AW - 2;

    // Word indices of the register map (byte offset / 4).
    localparam logic [WORD_W-1:0] W_SET   = 4'd0;  // 0x00 mask set
    localparam logic [WORD_W-1:0] W_UNSET = 4'd1;  // 0x04 mask clear
    localparam logic [WORD_W-1:0] W_MASK  = 4'd2;  // 0x08 mask view
    localparam logic [WORD_W-1:0] W_PEND  = 4'd3;  // 0x0C pending status
    localparam logic [WORD_W-1:0] W_ACK   = 4'd4;  // 0x10 pending clear
    localparam logic [WORD_W-1:0] W_SENSE = 4'd5;  // 0x14 mode
    localparam logic [WORD_W-1:0] W_EDGE  = 4'd6;  // 0x18 edge polarity
    localparam logic [WORD_W-1:0] W_LVL   = 4'd7;  // 0x1C level polarity
    localparam logic [WORD_W-1:0] W_NMI   = 4'd9;  // 0x24 nmi control
endpackage

// File: rtl/xint_sync.sv
// Module: two-flop synchroniser per line plus a third flop holding the
// previous synchronised sample for edge detection.
// Assumes inputs are asynchronous and wider than one clock when pulsed.
module xint_sync #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] smp_now,
    output logic [LINES-1:0] smp_prev
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic meta_q, stab_q, prev_q;
        // Capture, stabilise and delay one input line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                stab_q <= meta_q;
                prev_q <= stab_q;
            end
        end
        assign smp_now[g]  = stab_q;
        assign smp_prev[g] = prev_q;
    end
endmodule

// File: rtl/xint_detect.sv
// Module: per-line event detection and sticky pending status.
// Assumes sense=1 edge / 0 level, edge_pol=1 rising, lvl_pol=1 high.
module xint_detect #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] smp_now,
    input  logic [LINES-1:0] smp_prev,
    input  logic [LINES-1:0] sense,
    input  logic [LINES-1:0] edge_pol,
    input  logic [LINES-1:0] lvl_pol,
    input  logic [LINES-1:0] ack_bits,
    output logic [LINES-1:0] pending
);
    logic [LINES-1:0] hit;

    for (genvar g = 0; g < LINES; g++) begin : g_det
        logic rise, fall;
        assign rise = smp_now[g] & ~smp_prev[g];
        assign fall = ~smp_now[g] & smp_prev[g];
        // Choose the event for this line from its sense and polarity.
        always_comb begin
            if (sense[g]) hit[g] = edge_pol[g] ? rise : fall;
            else          hit[g] = (smp_now[g] == lvl_pol[g]);
        end
    end

    // Clear acknowledged bits, then set newly detected ones (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~ack_bits) | hit;
    end

    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((pending & $past(hit)) == $past(hit)));  // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_bits & ~hit)) |=> ((pending & $past(ack_bits & ~hit)) == '0));  // R3
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~hit)) |=> ((pending & ~$past(pending) & ~$past(hit)) == '0));  // R7
endmodule

// File: rtl/xint_regs.sv
// Module: register file holding mask, sense configuration and nmi control,
// with write decode and the combinational read mux.
// Assumes one write per cycle; reads have no side effects.
module xint_regs
    import xint_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LINES-1:0]  pending,
    output logic [DATA_W-1:0] rdata,
    output logic [LINES-1:0]  mask,
    output logic [LINES-1:0]  sense,
    output logic [LINES-1:0]  edge_pol,
    output logic [LINES-1:0]  lvl_pol,
    output logic [LINES-1:0]  ack_bits,
    output logic              nmi_en
);
    logic [WORD_W-1:0] word;
    logic [LINES-1:0]  wbits;

    assign word  = addr[REG_AW-1:2];
    assign wbits = wdata[LINES-1:0];

    // Widen a per-line vector to the data width with zero upper bits.
    function automatic logic [DATA_W-1:0] widen(input logic [LINES-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[LINES-1:0] = v;
        return r;
    endfunction

    // Pending-clear strobe for the detector in the cycle of the write.
    always_comb begin
        ack_bits = (we && word == W_ACK) ? wbits : '0;
    end

    // Mask update through its set-only and clear-only ports.
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else if (we && word == W_SET)   mask <= mask | wbits;
        else if (we && word == W_UNSET) mask <= mask & ~wbits;
    end

    // Sense configuration registers, implemented bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense    <= '0;
            edge_pol <= '0;
            lvl_pol  <= '0;
        end else if (we) begin
            if (word == W_SENSE) sense    <= wbits;
            if (word == W_EDGE)  edge_pol <= wbits;
            if (word == W_LVL)   lvl_pol  <= wbits;
        end
    end

    // Non-maskable enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  nmi_en <= 1'b0;
        else if (we && word == W_NMI) nmi_en <= wdata[0];
    end

    // Read mux; unmapped words and write-only ports return zero.
    always_comb begin
        unique case (word)
            W_MASK:  rdata = widen(mask);
            W_PEND:  rdata = widen(pending);
            W_SENSE: rdata = widen(sense);
            W_EDGE:  rdata = widen(edge_pol);
            W_LVL:   rdata = widen(lvl_pol);
            W_NMI:   rdata = {{(DATA_W-1){1'b0}}, nmi_en};
            default: rdata = '0;
        endcase
    end

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (we && word == W_SET) |=> ((mask & $past(wbits)) == $past(wbits)));  // R2
    AST_MASK_UNSET: assert property (@(posedge clk) disable iff (!rst_n)
        (we && word == W_UNSET) |=> ((mask & $past(wbits)) == '0));  // R2
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (word == W_SET || word == W_UNSET)) |=> $stable(mask));  // R2
endmodule

// File: rtl/xint_ctrl.sv
// Module: top of the external interrupt line controller.
// Assumes NUM_LINES in 1..32; ext_in is asynchronous to clk.
module xint_ctrl
    import xint_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [5:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] ext_in,
    output logic                 irq_out,
    output logic                 nmi_enable
);
    logic [NUM_LINES-1:0] smp_now, smp_prev, pending, mask;
    logic [NUM_LINES-1:0] sense, edge_pol, lvl_pol, ack_bits;

    xint_sync #(.LINES(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_in),
        .smp_now(smp_now), .smp_prev(smp_prev)
    );

    xint_detect #(.LINES(NUM_LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .smp_now(smp_now), .smp_prev(smp_prev),
        .sense(sense), .edge_pol(edge_pol), .lvl_pol(lvl_pol),
        .ack_bits(ack_bits), .pending(pending)
    );

    xint_regs #(.LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .pending(pending), .rdata(bus_rdata),
        .mask(mask), .sense(sense), .edge_pol(edge_pol), .lvl_pol(lvl_pol),
        .ack_bits(ack_bits), .nmi_en(nmi_enable)
    );

    // Merge enabled pending lines into the single request.
    assign irq_out = |(pending & mask);

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|pending && |mask));  // R4
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[5:2] == W_SENSE && NUM_LINES < 32) |-> ((bus_rdata >> NUM_LINES) == 32'd0));  // R5
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_out && !nmi_enable));  // R1
endmodule

// File: tb/xint_ctrl_tb.sv
module xint_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 5;
    localparam logic [NL-1:0] ALL = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] ext_in = '1;
    logic          irq_out, nmi_enable;

    int checks = 0, fails = 0;
    bit done = 0;

    // Spec model state
    logic [NL-1:0] m_s1, m_s2, m_prev, m_pend, m_mask, m_sense, m_edge, m_lvl;
    logic          m_nmi;

    xint_ctrl #(.NUM_LINES(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
        .irq_out(irq_out), .nmi_enable(nmi_enable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [NL-1:0] events(input logic [NL-1:0] s, p,
            input logic [NL-1:0] md, ed, lv);
        logic [NL-1:0] e;
        for (int i = 0; i < NL; i++)
            e[i] = md[i] ? (ed[i] ? (s[i] & ~p[i]) : (~s[i] & p[i])) : (s[i] == lv[i]);
        return e;
    endfunction

    function automatic logic [31:0] wide(input logic [NL-1:0] v);
        return {{(32-NL){1'b0}}, v};
    endfunction

    function automatic logic [31:0] model_read(input logic [5:0] a);
        case (a[5:2])
            4'd2: return wide(m_mask);
            4'd3: return wide(m_pend);
            4'd5: return wide(m_sense);
            4'd6: return wide(m_edge);
            4'd7: return wide(m_lvl);
            4'd9: return {31'd0, m_nmi};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: model next state from driven inputs, then advance.
    task automatic tick();
        logic [NL-1:0] ev, wb, n_pend, n_mask, n_sense, n_edge, n_lvl;
        logic n_nmi;
        ev = events(m_s2, m_prev, m_sense, m_edge, m_lvl);
        wb = bus_wdata[NL-1:0];
        n_pend = m_pend; n_mask = m_mask; n_sense = m_sense;
        n_edge = m_edge; n_lvl = m_lvl; n_nmi = m_nmi;
        if (bus_we) begin
            case (bus_addr[5:2])
                4'd0: n_mask = m_mask | wb;
                4'd1: n_mask = m_mask & ~wb;
                4'd4: n_pend = m_pend & ~wb;
                4'd5: n_sense = wb;
                4'd6: n_edge = wb;
                4'd7: n_lvl = wb;
                4'd9: n_nmi = bus_wdata[0];
                default: ;
            endcase
        end
        n_pend = n_pend | ev;
        @(posedge clk);
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_mask = '0;
            m_sense = '0; m_edge = '0; m_lvl = '0; m_nmi = 1'b0;
        end else begin
            m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_in;
            m_pend = n_pend; m_mask = n_mask; m_sense = n_sense;
            m_edge = n_edge; m_lvl = n_lvl; m_nmi = n_nmi;
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        bus_we = 1'b0; bus_addr = a; #1;
        check(tag, bus_rdata, model_read(a));
    endtask

    task automatic rd_lit(input logic [5:0] a, input logic [31:0] exp, input string tag);
        bus_we = 1'b0; bus_addr = a; #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic chk_irq(input string tag);
        check(tag, {31'd0, irq_out}, {31'd0, |(m_pend & m_mask)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [5:0] waddr [7];
        waddr = '{6'h00, 6'h04, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h24};
        void'($urandom(32'd20240607));
        m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_mask = '0;
        m_sense = '0; m_edge = '0; m_lvl = '0; m_nmi = 1'b0;
        @(negedge clk);
        repeat (3) tick();
        // R1: reset state
        rd_lit(6'h08, 0, "R1 mask");
        rd_lit(6'h0C, 0, "R1 status");
        rd_lit(6'h14, 0, "R1 mode");
        rd_lit(6'h24, 0, "R1 nmi reg");
        check("R1 irq", {31'd0, irq_out}, 0);
        check("R1 nmi out", {31'd0, nmi_enable}, 0);
        rst_n = 1'b1;
        repeat (4) tick();

        // R5: line count discovery
        wr(6'h14, 32'hFFFF_FFFF);
        rd_lit(6'h14, 32'h0000_001F, "R5 mode discovery");
        wr(6'h1C, 32'hFFFF_FFFF);
        rd_lit(6'h1C, 32'h0000_001F, "R5 level upper zero");
        wr(6'h18, 32'hFFFF_FFFF);
        rd_lit(6'h18, 32'h0000_001F, "R5 edge upper zero");
        wr(6'h00, 32'hFFFF_FFE0);
        rd_lit(6'h08, 0, "R5 mask upper ignored");
        wr(6'h14, 0); wr(6'h18, 0); wr(6'h1C, 0);
        repeat (4) tick();

        // R6/R8: level-low default, inputs idle high
        wr(6'h10, 32'h1F);
        tick();
        rd_lit(6'h0C, 0, "R6 idle high no pending");
        ext_in[1] = 1'b0;
        tick(); tick();
        rd_lit(6'h0C, 0, "R8 not before third edge");
        tick();
        rd_lit(6'h0C, 32'h2, "R8 set on third edge");
        wr(6'h10, 32'h2);
        rd_lit(6'h0C, 32'h2, "R10 clear loses to active level");
        check("R4 masked no irq", {31'd0, irq_out}, 0);
        wr(6'h00, 32'h2);
        check("R4 enabled irq", {31'd0, irq_out}, 1);
        wr(6'h00, 32'h0);
        rd_lit(6'h08, 32'h2, "R2 zero set no effect");
        wr(6'h04, 32'h0);
        rd_lit(6'h08, 32'h2, "R2 zero clear no effect");
        wr(6'h08, 32'h1F);
        rd_lit(6'h08, 32'h2, "R2 mask view read only");
        wr(6'h04, 32'h2);
        check("R4 disabled irq", {31'd0, irq_out}, 0);
        ext_in[1] = 1'b1;
        repeat (3) tick();
        wr(6'h10, 32'h2);
        rd_lit(6'h0C, 0, "R3 clear after release");
        // level high on line 0 (input high)
        wr(6'h1C, 32'h1);
        tick();
        rd_lit(6'h0C, 32'h1, "R6 active high level");

        // R7: edge sensing on line 2
        wr(6'h1C, 0);
        wr(6'h14, 32'h4); wr(6'h18, 32'h4);
        wr(6'h10, 32'h1F);
        ext_in[2] = 1'b0;
        repeat (3) tick();
        rd_lit(6'h0C, 0, "R7 falling ignored when rising");
        ext_in[2] = 1'b1;
        repeat (3) tick();
        rd_lit(6'h0C, 32'h4, "R7 rising edge");
        wr(6'h10, 32'h4);
        repeat (5) tick();
        rd_lit(6'h0C, 0, "R7 steady high not re-set");
        wr(6'h18, 0);
        ext_in[2] = 1'b0;
        repeat (3) tick();
        rd_lit(6'h0C, 32'h4, "R7 falling edge");

        // R9: nmi control
        wr(6'h24, 32'hFFFF_FFFF);
        rd_lit(6'h24, 32'h1, "R9 nmi bit only");
        check("R9 nmi out", {31'd0, nmi_enable}, 1);
        wr(6'h24, 0);
        check("R9 nmi off", {31'd0, nmi_enable}, 0);
        // R11: unmapped
        rd_lit(6'h20, 0, "R11 offset 0x20");
        rd_lit(6'h3C, 0, "R11 offset 0x3C");

        // Random phase against the spec model
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(7) == 0) ext_in[$urandom_range(NL-1)] ^= 1'b1;
            if ($urandom_range(3) == 0) begin
                bus_we = 1'b1;
                bus_addr = waddr[$urandom_range(6)];
                bus_wdata = $urandom;
            end else begin
                bus_we = 1'b0;
            end
            tick();
            bus_we = 1'b0;
            chk_irq("R4 random irq");
            if (c % 16 == 0) begin
                rd(6'h0C, "R3 R6 R7 random status");
                rd(6'h08, "R2 random mask");
                rd(6'h14, "R5 random mode");
                rd(6'h24, "R9 random nmi");
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule